// File: doc/BRIEF.md
# Two-Wire Converter Read Master

This block is the host side of a two-wire link to a serial delta-sigma converter. The link has a single clock, driven by the host, and a single return line. That return line does two jobs: its falling edge signals that a conversion is complete, and it then carries the result bits. The host gives commands to the converter only through how many clock pulses it sends and how long it holds the clock high. There are no separate control pins.

A request port accepts one of five commands. Four of them read a frame: a plain read, a read that also releases the line, a read that also starts self-calibration, and a read that leaves the converter asleep. The fifth command wakes a sleeping converter.

For a read, the master first waits for a fresh high-to-low transition on the return line. It then clocks out a frame with high and low times set by parameters, shifts in a 16-bit two's complement result MSB first, and presents the result with a one-cycle strobe. After a calibration or a wake, it waits for the converter to signal ready. A parameterised timeout limits that wait, and an error flag reports when the timeout expires.

Top module: `adc2w_reader`

## Requirements
- R1: While reset is applied and after it is released, `sclk` is 0 and `busy`, `result_valid` and `timeout_err` are all 0.
- R2: An accepted read drives no `sclk` pulse until the synchronised `rdy_dout` has been seen high and then low after the command was accepted. If the line is already low when the command arrives, the master waits for the next conversion.
- R3: Each `sclk` high phase lasts at least `T_HIGH` system clocks and each low phase between pulses lasts at least `T_LOW`. The defaults are 20 and 20 at 200 MHz, which gives 100 ns each and 5 MHz.
- R4: The return line is sampled in the last cycle of each high phase. The first 16 samples form `result`, MSB first, and `result_valid` is high for exactly one cycle once the 16th bit is in.
- R5: `cmd_op` is a 3-bit code. The code selects the frame length: 0 is a plain read of 24 pulses, 1 is a read plus release (25 pulses), 2 is a read plus calibration (26 pulses), 3 is a read then sleep (24 pulses, then `sclk` is held high), and 4 is wake.
- R6: `busy` is 1 from the cycle after a read command is accepted until its frame (and any wait that follows) ends. A command offered while `busy` is 1 is ignored.
- R7: After a calibration frame, `busy` stays 1 until `rdy_dout` goes low, and then returns to 0 with `timeout_err` at 0.
- R8: After a sleep frame, `sclk` stays 1 and `busy` is 0. Any command other than wake leaves `sclk` high and produces no pulse.
- R9: A wake command given during sleep drives `sclk` low in the cycle after acceptance and raises `busy` until `rdy_dout` goes low. A wake command given when not asleep is ignored.
- R10: If `rdy_dout` does not go low within `TIMEOUT` clocks after a calibration frame or a wake, `timeout_err` becomes 1 and `busy` drops. The flag stays 1 until the next accepted command clears it.
- R11: Codes 5 to 7 are ignored: they produce no pulse, do not raise `busy`, and leave `timeout_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (see R5) |
| busy | output | 1 | Command in progress; new commands ignored |
| result | output | 16 | Last captured conversion word, two's complement |
| result_valid | output | 1 | One-cycle strobe for a new `result` |
| timeout_err | output | 1 | Ready did not arrive in time after calibration or wake |
| sclk | output | 1 | Serial clock to the converter |
| rdy_dout | input | 1 | Ready / serial data from the converter |

## Verification
The bench builds the block with `T_HIGH` = 3, `T_LOW` = 2 and `TIMEOUT` = 60. With these values a full 26-pulse frame takes only about 130 clocks, and both timeout paths expire within a short run. A `T_HIGH` of 3 is the smallest value that still lets a bit launched at the rising edge pass through the two-stage synchroniser before it is sampled, so the bench exercises the tightest legal sampling point. The converter model in the bench changes its line on each `sclk` rising edge. It releases the line after the 25th edge, and it is told when to answer a calibration or a wake, or to stay silent.

// File: rtl/adc2w_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-wire converter read master.
// Assumes: command codes are fixed by the request port definition.
package adc2w_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_RELEASE = 3'd1,
        OP_CALIB   = 3'd2,
        OP_SLEEP   = 3'd3,
        OP_WAKE    = 3'd4
    } adc2w_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_WAIT_LOW,
        S_FRAME,
        S_WAIT_RDY,
        S_SLEEP
    } adc2w_state_e;

endpackage

// File: rtl/adc2w_pulse_gen.sv
`timescale 1ns/1ps
// Generates a burst of serial clock pulses with programmable high and low
// times counted in system clocks. Each pulse starts with its high phase.
// Gives a sample strobe in the last high cycle and a done strobe in the
// last low cycle of the final pulse.
// Assumes: start is only asserted while not running; num_pulses >= 1.
module adc2w_pulse_gen #(
    parameter int T_HIGH = 20,
    parameter int T_LOW  = 20,
    parameter int PW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] num_pulses,
    output logic          sclk,
    output logic          running,
    output logic          sample,
    output logic [PW-1:0] pulse_idx,
    output logic          done
);
    localparam int MAXT = (T_HIGH > T_LOW) ? T_HIGH : T_LOW;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] HI_LAST = CW'(T_HIGH - 1);
    localparam logic [CW-1:0] LO_LAST = CW'(T_LOW - 1);

    logic [CW-1:0] cnt;

    // Phase timer and pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            sclk      <= 1'b0;
            cnt       <= '0;
            pulse_idx <= '0;
        end else if (!running) begin
            if (start) begin
                running   <= 1'b1;
                sclk      <= 1'b1;
                cnt       <= '0;
                pulse_idx <= PW'(1);
            end
        end else if (sclk) begin
            if (cnt == HI_LAST) begin
                sclk <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == LO_LAST) begin
                cnt <= '0;
                if (pulse_idx == num_pulses) begin
                    running <= 1'b0;
                end else begin
                    sclk      <= 1'b1;
                    pulse_idx <= pulse_idx + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Strobes decoded from the phase timer.
    always_comb begin
        sample = running && sclk && (cnt == HI_LAST);
        done   = running && !sclk && (cnt == LO_LAST) && (pulse_idx == num_pulses);
    end

endmodule

// File: rtl/adc2w_capture.sv
`timescale 1ns/1ps
// Synchronises the shared ready/data line and shifts sampled bits in MSB
// first. The synchroniser resets to the idle-high level of the line.
// Assumes: SYNC_STAGES >= 1; the line is stable for SYNC_STAGES + 1 clocks
// before a shift strobe.
module adc2w_capture #(
    parameter int DATA_BITS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    input  logic                 shift_en,
    output logic                 line_s,
    output logic [DATA_BITS-1:0] data
);
    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            // Single-stage synchroniser.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_in;
            end
        end else begin : g_syncn
            // Multi-stage synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_s = sync_q[SYNC_STAGES-1];

    // Result shift register, MSB arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n)        data <= '0;
        else if (shift_en) data <= {data[DATA_BITS-2:0], line_s};
    end

endmodule

// File: rtl/adc2w_timer.sv
`timescale 1ns/1ps
// Counts clocks while run is high and flags expiry after LIMIT clocks.
// Clears whenever run is low.
// Assumes: LIMIT >= 1.
module adc2w_timer #(
    parameter int LIMIT = 64_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Elapsed-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expired)  cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/adc2w_reader.sv
`timescale 1ns/1ps
// Host master for a two-wire serial converter link. Accepts read, release,
// calibrate, sleep and wake commands. It waits for a fresh ready edge,
// clocks out a frame, returns the 16-bit result with a strobe, and watches
// for ready after calibration or wake with a timeout.
// Assumes: T_HIGH >= SYNC_STAGES + 1 so that a bit launched at the rising
// edge is through the synchroniser before it is sampled.
module adc2w_reader #(
    parameter int DATA_BITS    = 16,
    parameter int FRAME_PULSES = 24,
    parameter int T_HIGH       = 20,
    parameter int T_LOW        = 20,
    parameter int SYNC_STAGES  = 2,
    parameter int TIMEOUT      = 64_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    output logic                 busy,
    output logic [DATA_BITS-1:0] result,
    output logic                 result_valid,
    output logic                 timeout_err,
    output logic                 sclk,
    input  logic                 rdy_dout
);
    import adc2w_pkg::*;

    localparam int PW   = $clog2(FRAME_PULSES + 3);
    localparam int MAXT = (T_HIGH > T_LOW) ? T_HIGH : T_LOW;
    localparam int WCW  = $clog2(MAXT + 1);

    adc2w_state_e  state;
    adc2w_op_e     op_q;
    logic          sleep_q, err_q, rvalid_q;
    logic          line_s, shift_en, gen_start, gen_sclk, gen_run, gen_sample, gen_done;
    logic [PW-1:0] gen_idx, frame_len;
    logic          tmr_expired;

    // Frame length chosen by the stored command.
    always_comb begin
        case (op_q)
            OP_RELEASE: frame_len = PW'(FRAME_PULSES + 1);
            OP_CALIB:   frame_len = PW'(FRAME_PULSES + 2);
            default:    frame_len = PW'(FRAME_PULSES);
        endcase
    end

    assign gen_start = (state == S_WAIT_LOW) && !line_s;
    assign shift_en  = gen_sample && (state == S_FRAME) && (gen_idx <= PW'(DATA_BITS));

    adc2w_pulse_gen #(.T_HIGH(T_HIGH), .T_LOW(T_LOW), .PW(PW)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(gen_start), .num_pulses(frame_len),
        .sclk(gen_sclk), .running(gen_run), .sample(gen_sample),
        .pulse_idx(gen_idx), .done(gen_done)
    );

    adc2w_capture #(.DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .line_in(rdy_dout), .shift_en(shift_en),
        .line_s(line_s), .data(result)
    );

    adc2w_timer #(.LIMIT(TIMEOUT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == S_WAIT_RDY), .expired(tmr_expired)
    );

    // Command sequencing: arm, wait for ready, frame, post-frame wait, sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_READ;
            sleep_q  <= 1'b0;
            err_q    <= 1'b0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= shift_en && (gen_idx == PW'(DATA_BITS));
            case (state)
                S_IDLE: if (cmd_valid && cmd_op <= 3'(OP_SLEEP)) begin
                    op_q  <= adc2w_op_e'(cmd_op);
                    err_q <= 1'b0;
                    state <= S_ARM;
                end
                S_ARM:      if (line_s)  state <= S_WAIT_LOW;
                S_WAIT_LOW: if (!line_s) state <= S_FRAME;
                S_FRAME: if (gen_done) begin
                    case (op_q)
                        OP_CALIB: state <= S_WAIT_RDY;
                        OP_SLEEP: begin
                            state   <= S_SLEEP;
                            sleep_q <= 1'b1;
                        end
                        default:  state <= S_IDLE;
                    endcase
                end
                S_WAIT_RDY: begin
                    if (!line_s) begin
                        state <= S_IDLE;
                    end else if (tmr_expired) begin
                        state <= S_IDLE;
                        err_q <= 1'b1;
                    end
                end
                S_SLEEP: if (cmd_valid && cmd_op == 3'(OP_WAKE)) begin
                    op_q    <= OP_WAKE;
                    sleep_q <= 1'b0;
                    err_q   <= 1'b0;
                    state   <= S_WAIT_RDY;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign sclk         = gen_sclk | sleep_q;
    assign busy         = (state != S_IDLE) && (state != S_SLEEP);
    assign result_valid = rvalid_q;
    assign timeout_err  = err_q;

    // ---------------- checks ----------------
    logic [WCW-1:0] hi_run, lo_run;
    logic [PW-1:0]  chk_rises;
    logic           gen_sclk_d;

    // Measures pin phase lengths and counts generated rising edges per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run     <= '0;
            lo_run     <= WCW'(MAXT);
            chk_rises  <= '0;
            gen_sclk_d <= 1'b0;
        end else begin
            gen_sclk_d <= gen_sclk;
            if (sclk) begin
                lo_run <= '0;
                if (hi_run != WCW'(MAXT)) hi_run <= hi_run + 1'b1;
            end else begin
                hi_run <= '0;
                if (lo_run != WCW'(MAXT)) lo_run <= lo_run + 1'b1;
            end
            if (gen_start)                     chk_rises <= '0;
            else if (gen_sclk && !gen_sclk_d)  chk_rises <= chk_rises + 1'b1;
        end
    end

    p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_run >= WCW'(T_HIGH));
    p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> lo_run >= WCW'(T_LOW));
    p_start_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_run) |-> !$past(line_s));
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    p_pulse_total_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gen_done |-> chk_rises == frame_len);
    p_busy_holds_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(op_q));
    p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLEEP) |-> !gen_run);
    p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> !busy);

endmodule

// File: tb/adc2w_reader_tb.sv
`timescale 1ns/1ps
// Directed bench for adc2w_reader with a behavioural converter model.
module adc2w_reader_tb;
    localparam int TH = 3, TL = 2, TO = 60;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        busy, result_valid, timeout_err, sclk, rdy_dout;
    logic [15:0] result;

    always #2.5 clk = ~clk;

    adc2w_reader #(.T_HIGH(TH), .T_LOW(TL), .TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .result(result), .result_valid(result_valid),
        .timeout_err(timeout_err), .sclk(sclk), .rdy_dout(rdy_dout)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    // Converter model: a bit on each rising edge, the line released after edge 25.
    logic        dout_m = 1'b1;
    logic [15:0] word_m = '0;
    int          edge_n = 0, rises = 0;
    assign rdy_dout = dout_m;

    always @(posedge sclk) begin
        edge_n = edge_n + 1;
        rises  = rises + 1;
        if (edge_n <= 16)      dout_m <= word_m[16-edge_n];
        else if (edge_n <= 24) dout_m <= 1'b0;
        else                   dout_m <= 1'b1;
    end

    // Phase width monitor.
    int hr = 0, lr = 0, min_hi = 1000, min_lo = 1000;
    always @(posedge clk) begin
        if (sclk) begin
            hr++;
            if (lr > 0 && lr < min_lo) min_lo = lr;
            lr = 0;
        end else begin
            lr++;
            if (hr > 0 && hr < min_hi) min_hi = hr;
            hr = 0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=below 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic convert(input logic [15:0] v);
        word_m = v;
        edge_n = 0;
        dout_m = 1'b1;
        repeat (4) @(negedge clk);
        dout_m = 1'b0;
    endtask

    task automatic wait_valid(output bit got, output logic [15:0] val);
        got = 1'b0;
        val = '0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (result_valid) begin
                got = 1'b1;
                val = result;
                break;
            end
        end
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(sclk == 0 && busy == 0, "R1 sclk/busy in reset", {sclk, busy}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == 0, "R1 sclk after reset", sclk, 0);
        check(busy == 0 && result_valid == 0, "R1 busy/valid after reset", {busy, result_valid}, 0);
        check(timeout_err == 0, "R1 timeout_err after reset", timeout_err, 0);
    endtask

    task automatic t_read(input logic [2:0] op, input logic [15:0] v, input int exp_rises);
        bit got;
        logic [15:0] val;
        rises = 0;
        send(op);
        check(busy == 1, "R6 busy after accept", busy, 1);
        check(timeout_err == 0, "R10 error cleared by accepted command", timeout_err, 0);
        convert(v);
        wait_valid(got, val);
        check(got && val == v, "R4 result word", val, v);
        wait_idle(200);
        check(rises == exp_rises, "R5 pulse count", rises, exp_rises);
        check(busy == 0, "R6 busy released", busy, 0);
    endtask

    task automatic t_busy_ignore();
        bit got;
        logic [15:0] val;
        rises = 0;
        send(3'd1);
        convert(16'hC3A5);
        while (rises < 5) @(negedge clk);
        send(3'd2);
        wait_valid(got, val);
        check(got && val == 16'hC3A5, "R4 result with ignored command", val, 16'hC3A5);
        wait_idle(200);
        check(rises == 25, "R6 command while busy ignored", rises, 25);
        repeat (3) @(negedge clk);
        check(busy == 0, "R6 no calibration wait started", busy, 0);
    endtask

    task automatic t_wait_fresh();
        bit got;
        logic [15:0] val;
        rises = 0;
        send(3'd0);
        repeat (20) @(negedge clk);
        check(rises == 0 && busy == 1, "R2 no pulses on stale low line", rises, 0);
        convert(16'hFEDC);
        wait_valid(got, val);
        check(got && val == 16'hFEDC, "R2 read after fresh edge", val, 16'hFEDC);
        wait_idle(200);
    endtask

    task automatic t_calib(input bit reply);
        bit got;
        logic [15:0] val;
        rises = 0;
        send(3'd2);
        convert(16'h5A5A);
        wait_valid(got, val);
        check(got && val == 16'h5A5A, "R4 result before calibration", val, 16'h5A5A);
        while (!(rises == 26 && sclk == 0)) @(negedge clk);
        repeat (10) @(negedge clk);
        check(busy == 1, "R7 busy during calibration", busy, 1);
        if (reply) begin
            convert(16'h0000);
            wait_idle(30);
            check(busy == 0 && timeout_err == 0, "R7 ready after calibration", {busy, timeout_err}, 0);
        end else begin
            wait_idle(200);
            check(busy == 0 && timeout_err == 1, "R10 calibration timeout", {busy, timeout_err}, 1);
        end
    endtask

    task automatic t_unused();
        rises = 0;
        send(3'd5);
        send(3'd7);
        repeat (10) @(negedge clk);
        check(rises == 0 && busy == 0, "R11 unused codes ignored", rises, 0);
        check(timeout_err == 1, "R11 error flag unchanged", timeout_err, 1);
        send(3'd4);
        repeat (5) @(negedge clk);
        check(busy == 0 && sclk == 0, "R9 wake ignored when awake", {busy, sclk}, 0);
    endtask

    task automatic t_sleep(input bit reply);
        bit got;
        logic [15:0] val;
        rises = 0;
        send(3'd3);
        convert(16'h0F0F);
        wait_valid(got, val);
        check(got && val == 16'h0F0F, "R4 result before sleep", val, 16'h0F0F);
        while (rises < 25) @(negedge clk);
        repeat (20) @(negedge clk);
        check(sclk == 1 && busy == 0, "R8 sclk held high in sleep", {sclk, busy}, 2);
        check(rises == 25, "R5 24 pulses then hold", rises, 25);
        send(3'd0);
        repeat (10) @(negedge clk);
        check(sclk == 1 && busy == 0 && rises == 25, "R8 read ignored in sleep", rises, 25);
        send(3'd4);
        check(sclk == 0 && busy == 1, "R9 wake drives sclk low", {sclk, busy}, 1);
        repeat (8) @(negedge clk);
        if (reply) begin
            convert(16'h0000);
            wait_idle(30);
            check(busy == 0 && timeout_err == 0, "R9 ready after wake", {busy, timeout_err}, 0);
        end else begin
            wait_idle(200);
            check(busy == 0 && timeout_err == 1, "R10 wake timeout", {busy, timeout_err}, 1);
        end
    endtask

    initial begin
        t_reset();
        t_read(3'd1, 16'h8001, 25);
        t_read(3'd1, 16'h7FFE, 25);
        t_busy_ignore();
        t_read(3'd0, 16'h1234, 24);
        t_wait_fresh();
        t_calib(1'b1);
        t_calib(1'b0);
        t_unused();
        t_read(3'd1, 16'hFFFF, 25);
        t_sleep(1'b1);
        t_sleep(1'b0);
        t_read(3'd1, 16'h0000, 25);
        check(min_hi >= TH, "R3 minimum high width", min_hi, TH);
        check(min_lo >= TL, "R3 minimum low width", min_lo, TL);
        summary();
        $finish;
    end

endmodule